// File: doc/BRIEF.md
# Eight-Channel Start-Stop Drift Timer

This block digitizes drift times on eight channels against one common start. A single trigger pulse arms a shared enable, and from the following clock cycle every channel counter advances together on the common sample clock (50 MHz in the target system). Each channel has its own stop input. The first rising edge on that input freezes the channel's count, and the other channels keep running. All trigger and stop inputs are asynchronous logic pulses. They pass through identical synchronizer chains, so their latency cancels: a channel's final count equals the number of clock cycles between its stop rising and the trigger rising.

A host prepares a measurement with two commands. A clear command drops the shared enable and releases every per-channel stop flag. A load command zeroes all counters. After the measurement, the host steps a 3-bit channel select and reads a 16-bit word. That word carries the selected count and a status bit that shows whether the trigger has armed the block.

Top module: `drift_timer_bank`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `rd_word` reads 0 and the block is not armed.
- R2: A rising edge on `trig_in` sets the shared enable, and all eight counters then increment once per clock in the same cycles. With trigger and stop driven on the same clock phase, a channel whose stop rises D cycles (D >= 1) after the trigger ends with count D.
- R3: A rising stop edge on one channel freezes only that channel's count. The count then holds until a load command.
- R4: A stop edge that reaches the enable logic while the shared enable is inactive is ignored. This includes a stop that rises in the same cycle as the trigger. A later stop edge on that channel still freezes it.
- R5: A counter that reaches 4095 stays at 4095 and does not wrap.
- R6: `load_cmd` zeroes every counter at the next clock edge. When it coincides with an increment, the load takes priority, and counting resumes from zero on the following edge.
- R7: `clear_cmd` drops the shared enable and releases all stop flags. It does not change the counts, so a channel that is triggered again without a load continues from its held count.
- R8: `rd_word` is registered one cycle after `chan_sel`. Bits 11:0 hold the selected channel's count (channel index = `chan_sel` value), bits 14:12 are zero, and bit 15 is the shared enable (1 = armed).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous common start pulse |
| stop_in | input | 8 | Asynchronous per-channel stop pulses, bit i is channel i |
| load_cmd | input | 1 | Zero all counters (one cycle pulse) |
| clear_cmd | input | 1 | Disarm and release stop flags (one cycle pulse) |
| chan_sel | input | 3 | Channel whose count is read |
| rd_word | output | 16 | Registered readout: {armed, 3'b000, count} |

## Verification
Two functions can act on a counter in the same cycle: the load command and a normal increment of a running channel. The bench raises `load_cmd` in the middle of a measurement, on an edge where the channel would otherwise count. It then stops the channel a known number of cycles later and checks that the final count equals the edges after the load plus one edge, not the value the increment would have given. A second collision, a stop that rises in the same cycle as the trigger, is judged by showing that the channel ignores it and later freezes on its next stop edge.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  localparam int CNT_W  = 12;
  localparam int N_CH   = 8;
  localparam int WORD_W = 16;
  localparam int SYNC_N = 2;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/dtb_sync_edge.sv
// Multi-flop synchronizer per bit followed by a rising-edge detector.
module dtb_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = dtb_pkg::SYNC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  logic [STAGES:0][W-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s <= STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/dtb_chan.sv
// One channel: saturating counter gated by shared enable and own stop flag.
module dtb_chan #(
  parameter int CW = dtb_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          stop_rise_i,
  input  logic          load_i,
  input  logic          clear_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          halted_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)               halted_q <= 1'b0;
    else if (arm_i && stop_rise_i)    halted_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || load_i)                               cnt_q <= '0;
    else if (arm_i && !halted_q && cnt_q != CMAX)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == CMAX) |=> cnt_q == CMAX);
  a_r3_frozen_holds: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !load_i) |=> $stable(cnt_q));
  a_r6_load_zero: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == '0);
  a_r4_idle_stop_ignored: assert property (@(posedge clk) disable iff (rst)
    (!arm_i && !halted_q) |=> !halted_q);
endmodule

// File: rtl/dtb_readout.sv
// Registered channel select and readout word packing.
module dtb_readout #(
  parameter int N  = dtb_pkg::N_CH,
  parameter int CW = dtb_pkg::CNT_W,
  parameter int WW = dtb_pkg::WORD_W,
  localparam int SW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0][CW-1:0] cnt_i,
  input  logic [SW-1:0]      sel_i,
  input  logic               armed_i,
  output logic [WW-1:0]      word_o
);
  localparam int PAD_W = WW - 1 - CW;

  logic [WW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= {armed_i, {PAD_W{1'b0}}, cnt_i[sel_i]};
  end

  assign word_o = word_q;

  a_r8_flag_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> word_q[WW-1] == $past(armed_i));
  a_r8_count_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> word_q[CW-1:0] == $past(cnt_i[sel_i]));
endmodule

// File: rtl/drift_timer_bank.sv
module drift_timer_bank #(
  parameter int N_CH   = dtb_pkg::N_CH,
  parameter int CNT_W  = dtb_pkg::CNT_W,
  parameter int WORD_W = dtb_pkg::WORD_W,
  parameter int SYNC_N = dtb_pkg::SYNC_N,
  localparam int SEL_W = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_in,
  input  logic [N_CH-1:0]   stop_in,
  input  logic              load_cmd,
  input  logic              clear_cmd,
  input  logic [SEL_W-1:0]  chan_sel,
  output logic [WORD_W-1:0] rd_word
);
  logic [N_CH:0]              rise_w;
  logic                       armed_q;
  logic [N_CH-1:0][CNT_W-1:0] cnt_w;

  // Trigger rides in the top bit so its latency matches every stop bit.
  dtb_sync_edge #(.W(N_CH+1), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({trig_in, stop_in}),
    .rise_o  (rise_w)
  );

  always_ff @(posedge clk) begin
    if (rst || clear_cmd) armed_q <= 1'b0;
    else if (rise_w[N_CH]) armed_q <= 1'b1;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    dtb_chan #(.CW(CNT_W)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .arm_i       (armed_q),
      .stop_rise_i (rise_w[c]),
      .load_i      (load_cmd),
      .clear_i     (clear_cmd),
      .cnt_o       (cnt_w[c])
    );
  end

  dtb_readout #(.N(N_CH), .CW(CNT_W), .WW(WORD_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .cnt_i   (cnt_w),
    .sel_i   (chan_sel),
    .armed_i (armed_q),
    .word_o  (rd_word)
  );

  a_r2_trigger_arms: assert property (@(posedge clk) disable iff (rst)
    (rise_w[N_CH] && !clear_cmd) |=> armed_q);
  a_r7_clear_disarms: assert property (@(posedge clk) disable iff (rst)
    clear_cmd |=> !armed_q);
endmodule

// File: tb/sim_drift_timer_bank.sv
`timescale 1ns/1ps
module sim_drift_timer_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_in = 1'b0;
  logic [7:0]  stop_in = '0;
  logic        load_cmd = 1'b0;
  logic        clear_cmd = 1'b0;
  logic [2:0]  chan_sel = '0;
  logic [15:0] rd_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  drift_timer_bank u0 (
    .clk(clk), .rst(rst), .trig_in(trig_in), .stop_in(stop_in),
    .load_cmd(load_cmd), .clear_cmd(clear_cmd), .chan_sel(chan_sel),
    .rd_word(rd_word)
  );

  // Stop delays per channel, byte i = channel i, cycles after trigger.
  localparam logic [63:0] VEC [4] = '{
    64'h08_07_06_05_04_03_02_01,
    64'hC8_64_32_19_0A_05_02_01,
    64'h11_22_33_44_55_66_77_88,
    64'h01_C7_02_63_2A_0F_B4_03
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic read_ch(input int ch, output logic [15:0] w);
    chan_sel = ch[2:0];
    @(negedge clk);
    w = rd_word;
  endtask

  task automatic prep();
    trig_in = 1'b0; stop_in = '0;
    repeat (4) @(negedge clk);
    clear_cmd = 1'b1; @(negedge clk); clear_cmd = 1'b0;
    load_cmd = 1'b1;  @(negedge clk); load_cmd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] w;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 reset word", rd_word, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", rd_word, 16'h0000);

    // Table walk: R2 common start, R3 per-channel stop, R8 select/format
    for (int v = 0; v < 4; v++) begin
      prep();
      trig_in = 1'b1;
      for (int n = 0; n <= 210; n++) begin
        for (int c = 0; c < 8; c++)
          if (int'(VEC[v][8*c +: 8]) == n) stop_in[c] = 1'b1;
        @(negedge clk);
      end
      for (int c = 0; c < 8; c++) begin
        read_ch(c, w);
        chk("R2 R3 R8 table count", w, {1'b1, 3'b000, 4'h0, VEC[v][8*c +: 8]});
      end
    end

    // R4: stop rising with the trigger is ignored; later stop freezes
    prep();
    for (int n = 0; n <= 50; n++) begin
      if (n == 0) begin trig_in = 1'b1; stop_in[0] = 1'b1; end
      if (n == 3) stop_in[0] = 1'b0;
      if (n == 10) stop_in[0] = 1'b1;
      if (n == 40) stop_in[7:1] = '1;
      @(negedge clk);
    end
    read_ch(0, w); chk("R4 ignored idle stop", w, 16'h800A);
    read_ch(1, w); chk("R4 other chan", w, 16'h8028);

    // R6: load collides with increment mid-count; R3 freeze after
    prep();
    for (int n = 0; n <= 60; n++) begin
      if (n == 0) trig_in = 1'b1;
      load_cmd = (n == 20);
      if (n == 50) stop_in = '1;
      @(negedge clk);
    end
    read_ch(1, w); chk("R6 load wins over increment", w, 16'h8020);
    load_cmd = 1'b1; @(negedge clk); load_cmd = 1'b0;
    read_ch(4, w); chk("R6 load zeroes frozen", w, 16'h8000);

    // R7: clear disarms, keeps counts, releases stop flags
    prep();
    for (int n = 0; n <= 20; n++) begin
      if (n == 0) trig_in = 1'b1;
      if (n == 10) stop_in = '1;
      @(negedge clk);
    end
    trig_in = 1'b0; stop_in = '0;
    repeat (4) @(negedge clk);
    clear_cmd = 1'b1; @(negedge clk); clear_cmd = 1'b0;
    read_ch(2, w); chk("R7 clear keeps count, flag low", w, 16'h000A);
    repeat (3) @(negedge clk);
    for (int n = 0; n <= 20; n++) begin
      if (n == 0) trig_in = 1'b1;
      if (n == 5) stop_in = '1;
      @(negedge clk);
    end
    read_ch(2, w); chk("R7 resume after clear", w, 16'h800F);

    // R5 saturation
    prep();
    trig_in = 1'b1;
    repeat (4200) @(negedge clk);
    read_ch(5, w); chk("R5 saturate", w, 16'h8FFF);
    repeat (20) @(negedge clk);
    read_ch(0, w); chk("R5 still saturated", w, 16'h8FFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule